// File: doc/BRIEF.md
# Oscillator Calibration Sequencer

This block runs the calibration step of a clock-synthesis loop's on-chip oscillator. Software programs a small register set. Each register has a staging copy, which software writes, and an active copy, which the logic uses. Staged values reach the active copy only when software issues an update command. A calibration starts when the active calibrate bit changes from 0 to 1, and only if three conditions hold: automatic holdover is off, the output divider is not in static mode, and the reference is present.

While a calibration runs, the block raises a sync request so that the downstream outputs hold a static level. It derives a slow calibration tick from the reference clock. The reference is first divided by the programmed R value and then by a selectable calibration divider of 2, 4, 8 or 16. The run lasts for a fixed number of these ticks. At the end the block drops the sync request and sets a done flag that software can read back. A stub tuning code advances on every tick in place of the real tuning search. If the reference disappears during a run, the block abandons the run and does not set the done flag.

Top module: `osc_cal_seq`

## Requirements
- R1: After reset the active calibrate bit, `sync_req`, `cal_done` and status bit 6 are all 0, and the staging registers read back 0.
- R2: A write to the control register (address 0) or the R register (address 1) has no effect on operation until a 1 is written to bit 0 of the update register (address 2). The update copies both staging registers into the active set.
- R3: A calibration starts only on a 0-to-1 change of the active calibrate bit (control bit 0). An update that leaves the bit at 1 starts nothing.
- R4: The calibration tick period is R_eff × D reference cycles. D is selected by control bits [2:1]: 00 gives 2, 01 gives 4, 10 gives 8 and 11 gives 16.
- R5: A calibration lasts exactly CAL_TICKS ticks, so `sync_req` stays high for CAL_TICKS × R_eff × D cycles. It rises on the clock edge after the update that starts the run.
- R6: `sync_req` is high for the whole run and low at all other times.
- R7: When a run completes, `cal_done` and status bit 6 (read at address 3) become 1 and stay at 1.
- R8: A calibrate edge is ignored unless `holdover_auto` is 0, `outdiv_static` is 0 and `ref_present` is 1.
- R9: If `ref_present` falls during a run, the run aborts on the next edge. `sync_req` drops and `cal_done` stays 0.
- R10: `cal_done` is cleared on the edge that starts a new run.
- R11: The R register holds a 14-bit value in bits [13:0]. R = 0 acts as R = 1, so R_eff = max(R, 1).
- R12: `tune_code` is cleared when a run starts and increments by one on each tick. After a full run it equals CAL_TICKS modulo 2^CODE_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 R, 2 update) |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 2 | Read address (3 status) |
| rd_data | output | DATA_W | Read data, combinational |
| ref_present | input | 1 | Reference present indication |
| holdover_auto | input | 1 | Automatic holdover enabled |
| outdiv_static | input | 1 | Output divider in static mode |
| sync_req | output | 1 | Output hold request during calibration |
| cal_done | output | 1 | Calibration completed |
| tune_code | output | CODE_W | Stub tuning code |

## Verification
The bench builds the block with CAL_TICKS = 12 and leaves the other parameters at their defaults. A shorter run makes it affordable to measure the full sync window, in cycles, for every divider select, for random R values and for R = 0. The same setting keeps the many start, retrigger, interlock and abort scenarios within a few thousand cycles. The tick-count comparison and the wraparound of the tuning code are generic in CAL_TICKS, so the short setting exercises the same logic that the default of 4400 uses.

// File: rtl/osc_cal_pkg.sv
package osc_cal_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_RDIV = 2'd1;
  localparam logic [1:0] ADDR_UPD  = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;
  localparam int GO_BIT   = 0;
  localparam int DIV_LSB  = 1;
  localparam int DONE_BIT = 6;

  // calibration divider select -> division factor minus one (1,3,7,15)
  function automatic logic [3:0] div_last(input logic [1:0] sel);
    return 4'((2 << sel) - 1);
  endfunction

  // R value -> prescaler terminal count (R=0 treated as R=1)
  function automatic logic [13:0] r_last(input logic [13:0] r);
    return (r == 14'd0) ? 14'd0 : r - 14'd1;
  endfunction
endpackage

// File: rtl/osc_cal_regs.sv
module osc_cal_regs
  import osc_cal_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int R_W    = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              done_in,
  output logic              act_go,
  output logic [1:0]        act_div,
  output logic [R_W-1:0]    act_r
);
  logic [DATA_W-1:0] ctrl_stg, r_stg;
  logic              do_update;

  assign do_update = wr_en && (wr_addr == ADDR_UPD) && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_stg <= '0;
      r_stg    <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_CTRL) ctrl_stg <= wr_data;
      if (wr_addr == ADDR_RDIV) r_stg    <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_go  <= 1'b0;
      act_div <= '0;
      act_r   <= '0;
    end else if (do_update) begin
      act_go  <= ctrl_stg[GO_BIT];
      act_div <= ctrl_stg[DIV_LSB +: 2];
      act_r   <= r_stg[R_W-1:0];
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_CTRL: rd_data = ctrl_stg;
      ADDR_RDIV: rd_data = r_stg;
      ADDR_STAT: rd_data[DONE_BIT] = done_in;
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/osc_cal_tickgen.sv
module osc_cal_tickgen
  import osc_cal_pkg::*;
#(
  parameter int R_W = 14
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           run,
  input  logic [R_W-1:0] r_val,
  input  logic [1:0]     div_sel,
  output logic           tick
);
  logic [R_W-1:0] pre;
  logic [3:0]     sub;
  logic [R_W-1:0] pre_end;
  logic [3:0]     sub_end;
  logic           pre_wrap;

  assign pre_end  = R_W'(r_last(14'(r_val)));
  assign sub_end  = div_last(div_sel);
  assign pre_wrap = (pre == pre_end);
  assign tick     = run && pre_wrap && (sub == sub_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
      sub <= '0;
    end else if (clr || !run) begin
      pre <= '0;
      sub <= '0;
    end else if (pre_wrap) begin
      pre <= '0;
      sub <= (sub == sub_end) ? 4'd0 : sub + 4'd1;
    end else begin
      pre <= pre + 1'b1;
    end
  end
endmodule

// File: rtl/osc_cal_fsm.sv
module osc_cal_fsm #(
  parameter int CAL_TICKS = 4400,
  parameter int CODE_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_go,
  input  logic              permit,
  input  logic              ref_ok,
  input  logic              tick,
  output logic              running,
  output logic              done,
  output logic [CODE_W-1:0] code,
  output logic              ev_start,
  output logic              ev_abort,
  output logic              ev_finish
);
  localparam int TC_W = $clog2(CAL_TICKS + 1);
  localparam logic [TC_W-1:0] LAST = TC_W'(CAL_TICKS - 1);

  logic            go_q;
  logic [TC_W-1:0] tcnt;

  assign ev_start  = act_go && !go_q && permit;
  assign ev_abort  = running && !ref_ok;
  assign ev_finish = running && ref_ok && tick && (tcnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q    <= 1'b0;
      running <= 1'b0;
      done    <= 1'b0;
      tcnt    <= '0;
      code    <= '0;
    end else begin
      go_q <= act_go;
      if (ev_start) begin
        running <= 1'b1;
        done    <= 1'b0;
        tcnt    <= '0;
        code    <= '0;
      end else if (ev_abort) begin
        running <= 1'b0;
      end else if (running && tick) begin
        code <= code + 1'b1;
        tcnt <= tcnt + 1'b1;
        if (ev_finish) begin
          running <= 1'b0;
          done    <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/osc_cal_seq.sv
module osc_cal_seq #(
  parameter int CAL_TICKS = 4400,
  parameter int R_W       = 14,
  parameter int DATA_W    = 16,
  parameter int CODE_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ref_present,
  input  logic              holdover_auto,
  input  logic              outdiv_static,
  output logic              sync_req,
  output logic              cal_done,
  output logic [CODE_W-1:0] tune_code
);
  logic           act_go;
  logic [1:0]     act_div;
  logic [R_W-1:0] act_r;
  logic           permit, cal_tick, running;
  logic           cal_start, cal_abort, cal_finish;

  assign permit   = ref_present && !holdover_auto && !outdiv_static;
  assign sync_req = running;

  osc_cal_regs #(.DATA_W(DATA_W), .R_W(R_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .done_in(cal_done), .act_go(act_go), .act_div(act_div), .act_r(act_r)
  );

  osc_cal_tickgen #(.R_W(R_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(cal_start), .run(running),
    .r_val(act_r), .div_sel(act_div), .tick(cal_tick)
  );

  osc_cal_fsm #(.CAL_TICKS(CAL_TICKS), .CODE_W(CODE_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .act_go(act_go), .permit(permit),
    .ref_ok(ref_present), .tick(cal_tick), .running(running),
    .done(cal_done), .code(tune_code), .ev_start(cal_start),
    .ev_abort(cal_abort), .ev_finish(cal_finish)
  );
endmodule

// File: rtl/osc_cal_seq_chk.sv
module osc_cal_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic sync_req,
  input logic cal_done,
  input logic ref_present,
  input logic holdover_auto,
  input logic outdiv_static,
  input logic cal_tick,
  input logic cal_start,
  input logic cal_abort,
  input logic cal_finish
);
  assert_start_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |-> (ref_present && !holdover_auto && !outdiv_static));

  assert_sync_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_req) |-> $past(cal_start));

  assert_start_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |=> (sync_req && !cal_done));

  assert_done_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_done) |-> ($past(cal_finish) && !sync_req));

  assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_abort && !cal_start) |=> (!sync_req && !cal_done));

  assert_tick_in_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cal_tick |-> sync_req);

  assert_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(sync_req && cal_done));
endmodule

bind osc_cal_seq osc_cal_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sync_req(sync_req), .cal_done(cal_done),
  .ref_present(ref_present), .holdover_auto(holdover_auto),
  .outdiv_static(outdiv_static), .cal_tick(cal_tick),
  .cal_start(cal_start), .cal_abort(cal_abort), .cal_finish(cal_finish)
);

// File: tb/osc_cal_seq_tb.sv
module osc_cal_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CT = 12;

  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0;
  logic [1:0]  wr_addr = 0, rd_addr = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] rd_data;
  logic        ref_present = 1, holdover_auto = 0, outdiv_static = 0;
  logic        sync_req, cal_done;
  logic [7:0]  tune_code;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  osc_cal_seq #(.CAL_TICKS(CT)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ref_present(ref_present), .holdover_auto(holdover_auto),
    .outdiv_static(outdiv_static), .sync_req(sync_req),
    .cal_done(cal_done), .tune_code(tune_code)
  );

  function automatic int exp_cycles(int r, int sel);
    int re = (r == 0) ? 1 : r;
    int d  = 1;
    for (int i = 0; i <= sel; i++) d = d * 2;
    return CT * re * d;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic status_done(output int v);
    rd_addr = 2'd3; #1; v = rd_data[6];
  endtask

  // counts cycles sync is high; first sample is the negedge after the start edge
  task automatic measure(output int n, output int done_first);
    n = 0;
    @(negedge clk);
    done_first = cal_done;
    while (sync_req && n < 100000) begin n++; @(negedge clk); end
  endtask

  task automatic run_cal(int r, int sel, string tag);
    int n, df, st;
    wr(2'd1, 16'(r));
    wr(2'd0, 16'd0); wr(2'd2, 16'd1);
    wr(2'd0, 16'((sel << 1) | 1)); wr(2'd2, 16'd1);
    measure(n, df);
    chk({tag, " R4 R5 R6 R11 sync window"}, n, exp_cycles(r, sel));
    chk({tag, " R10 done cleared at start"}, df, 0);
    chk({tag, " R7 cal_done"}, cal_done, 1);
    status_done(st);
    chk({tag, " R7 status bit6"}, st, 1);
    chk({tag, " R12 tune_code"}, tune_code, CT % 256);
  endtask

  task automatic expect_no_start(string tag);
    repeat (3) begin
      @(negedge clk);
      chk(tag, sync_req, 0);
    end
  endtask

  initial begin
    int v, n, df;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 sync", sync_req, 0);
    chk("R1 done", cal_done, 0);
    status_done(v); chk("R1 status", v, 0);
    rd_addr = 2'd0; #1; chk("R1 ctrl readback", rd_data, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 staging write alone does nothing
    wr(2'd0, 16'd1);
    rd_addr = 2'd0; #1; chk("R2 staged readback", rd_data, 1);
    expect_no_start("R2 no start without update");
    wr(2'd2, 16'd1);
    measure(n, df);
    chk("R2 R5 run after update (R=0,D=2)", n, exp_cycles(0, 0));

    // R3 update with bit still 1 does not retrigger
    wr(2'd2, 16'd1);
    expect_no_start("R3 no retrigger");
    chk("R3 done held", cal_done, 1);

    // directed: every divider select, and R=0 (R11)
    for (int s = 0; s < 4; s++) run_cal(1, s, "directed");
    run_cal(0, 3, "R11 r0");
    // random
    for (int k = 0; k < 8; k++) run_cal(int'($urandom_range(0, 5)), int'($urandom_range(0, 3)), "random");

    // R8 interlocks
    for (int c = 0; c < 3; c++) begin
      wr(2'd0, 16'd0); wr(2'd2, 16'd1);
      holdover_auto = (c == 0); outdiv_static = (c == 1); ref_present = (c != 2);
      wr(2'd0, 16'd1); wr(2'd2, 16'd1);
      expect_no_start("R8 interlock");
      holdover_auto = 0; outdiv_static = 0; ref_present = 1;
    end
    expect_no_start("R3 R8 edge consumed");

    // R9 abort
    wr(2'd1, 16'd3);
    wr(2'd0, 16'd0); wr(2'd2, 16'd1);
    wr(2'd0, 16'd1); wr(2'd2, 16'd1);
    repeat (5) @(negedge clk);
    chk("R9 running before abort", sync_req, 1);
    ref_present = 0;
    @(negedge clk);
    chk("R9 sync dropped", sync_req, 0);
    chk("R9 done stays 0", cal_done, 0);
    status_done(v); chk("R9 status 0", v, 0);
    ref_present = 1;
    expect_no_start("R9 stays idle");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule